// File: doc/BRIEF.md
# Aligning Bus Interface Unit with Wait States

This unit sits between a processor-side request port and a 16-bit external data bus built from two byte lanes. Each request names a byte address, a size (one byte or one 16-bit word), a direction and, for writes, the data. The unit runs one or two external bus cycles to serve it. Each cycle has the clock states T1, T2, T3 and T4, and T3 may be followed by wait states. When the whole access has ended, it raises a one-clock completion pulse together with the assembled read data.

A word whose low byte sits at an even address moves in a single cycle with both lanes enabled. A byte moves on the lane chosen by address bit 0. A word at an odd address is split into two complete byte cycles. The first moves the low byte on the high lane at the request address. The second moves the high byte on the low lane at the address plus one. The external Ready input is sampled at the end of T3 and at the end of each wait state. While it is low, the cycle is stretched one whole clock at a time. Read data is captured only at the clock edge where Ready is seen high.

Top module: `bus_if_unit`

## Requirements
- R1: After reset the unit is idle: `req_busy`, `req_done`, `bus_rd`, `bus_wr` and `bus_doe` are low, and `bus_be` is 2'b00.
- R2: A request presented while the unit is idle is accepted at the next clock edge. With Ready high, one bus cycle lasts exactly four clocks. `req_done` is high in the fifth clock after the acceptance edge for a one-cycle access, and in the ninth clock for a split access.
- R3: The read or write strobe is low in T1 and T4. It first goes high in T2, which is the second clock after acceptance, and it stays high through T3 and every wait state.
- R4: Each clock in which Ready is low at a sample point (end of T3 or end of a wait state) lengthens that bus cycle by exactly one clock. The cycle count of an access is 1 + sum over its cycles of (4 + waits).
- R5: Byte enables, with bit 0 for the low lane (data bits 7:0) and bit 1 for the high lane (bits 15:8), are as follows. An even word uses 2'b11. An even byte uses 2'b01. An odd byte uses 2'b10. No strobe is raised with both enables low.
- R6: A word at an odd address A takes two bus cycles. The first drives address A with enables 2'b10 and request byte 0 on the high lane. The second drives address A+1 with enables 2'b01 and request byte 1 on the low lane. Address and enables hold steady while a strobe is active.
- R7: For a read, `req_rdata` at the completion pulse holds the requested bytes in request order: low byte in bits 7:0, high byte in bits 15:8. A byte read returns zero in bits 15:8.
- R8: Write data is driven (`bus_doe` high) in every clock in which `bus_wr` is high, and it holds steady over that span. A lane whose enable is low is driven as zero. The memory then holds exactly the bytes the request named.
- R9: `req_done` is a single-clock pulse, raised only after the last bus cycle of an access. A new request presented during the pulse clock is accepted at the following edge.
- R10: `req_busy` is high from the clock after acceptance up to, but not including, the completion clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when the unit is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 2*LW | Write data; a byte write uses bits 7:0 |
| req_busy | output | 1 | An access is in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 2*LW | Assembled read data, valid with the completion pulse |
| bus_addr | output | AW | External byte address, driven during bus cycles |
| bus_be | output | 2 | Lane enables (bit 0 low lane, bit 1 high lane) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_doe | output | 1 | Write data output enable |
| bus_dout | output | 2*LW | Write data lanes |
| bus_din | input | 2*LW | Read data lanes |
| bus_ready | input | 1 | High when the external side can finish the data phase |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same clock. This is because the pulse clock is already idle. The bench provokes the overlap by issuing every request in the clock where the previous pulse is seen, so the whole sweep runs back to back. It judges the result by counting clocks from each acceptance edge to its own pulse against 1 + sum(4 + waits). It also checks that the pulse is low again one edge after the new acceptance. A second overlap is a wait state on the second half of a split word: Ready is held low for the same number of clocks in both cycles, and the count must include both stretches.

// File: rtl/bif_pkg.sv
package bif_pkg;
   typedef enum logic [2:0] {
      TS_IDLE,
      TS_T1,
      TS_T2,
      TS_T3,
      TS_TW,
      TS_T4
   } tstate_e;

   localparam int BIF_LANES = 2;
endpackage

// File: rtl/bif_seq.sv
module bif_seq
   import bif_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    ready,
   input  logic    last,
   output tstate_e state,
   output logic    phase,
   output logic    done,
   output logic    strobe,
   output logic    sample
);
   tstate_e state_nxt;
   logic    phase_nxt;

   always_comb begin
      state_nxt = state;
      phase_nxt = phase;
      unique case (state)
         TS_IDLE: if (start) begin
            state_nxt = TS_T1;
            phase_nxt = 1'b0;
         end
         TS_T1:   state_nxt = TS_T2;
         TS_T2:   state_nxt = TS_T3;
         TS_T3,
         TS_TW:   state_nxt = ready ? TS_T4 : TS_TW;
         TS_T4: begin
            if (last) begin
               state_nxt = TS_IDLE;
            end else begin
               state_nxt = TS_T1;
               phase_nxt = 1'b1;
            end
         end
         default: state_nxt = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TS_IDLE;
         phase <= 1'b0;
         done  <= 1'b0;
      end else begin
         state <= state_nxt;
         phase <= phase_nxt;
         done  <= (state == TS_T4) && last;
      end
   end

   assign strobe = (state == TS_T2) || (state == TS_T3) || (state == TS_TW);
   assign sample = ((state == TS_T3) || (state == TS_TW)) && ready;
endmodule

// File: rtl/bif_plan.sv
module bif_plan
   import bif_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic                 word,
   input  logic [AW-1:0]        base,
   input  logic                 phase,
   output logic [AW-1:0]        addr,
   output logic [BIF_LANES-1:0] be,
   output logic [BIF_LANES-1:0] src
);
   logic odd;
   logic split;

   assign odd   = base[0];
   assign split = word && odd;
   assign addr  = base + AW'(phase);

   always_comb begin
      if (!odd)
         be = word ? 2'b11 : 2'b01;
      else if (split && phase)
         be = 2'b01;
      else
         be = 2'b10;
   end

   for (genvar l = 0; l < BIF_LANES; l++) begin : g_src
      assign src[l] = (word && !odd) ? 1'(l) : phase;
   end
endmodule

// File: rtl/bus_if_unit.sv
module bus_if_unit
   import bif_pkg::*;
#(
   parameter int AW = 16,
   parameter int LW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [AW-1:0]     req_addr,
   input  logic [2*LW-1:0]   req_wdata,
   output logic              req_busy,
   output logic              req_done,
   output logic [2*LW-1:0]   req_rdata,
   output logic [AW-1:0]     bus_addr,
   output logic [1:0]        bus_be,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_doe,
   output logic [2*LW-1:0]   bus_dout,
   input  logic [2*LW-1:0]   bus_din,
   input  logic              bus_ready
);
   localparam int DW = LW * BIF_LANES;

   if (AW < 2) begin : g_bad_aw
      $error("bus_if_unit: AW must be at least 2");
   end
   if (LW < 1) begin : g_bad_lw
      $error("bus_if_unit: LW must be at least 1");
   end

   tstate_e              state;
   logic                 phase, strobe, sample, last, accept, busy;
   logic [AW-1:0]        q_addr, plan_addr;
   logic                 q_word, q_write;
   logic [DW-1:0]        q_wdata, rdata_q, rdata_nxt;
   logic [BIF_LANES-1:0] plan_be, plan_src;

   assign busy   = (state != TS_IDLE);
   assign accept = req_valid && !busy;
   assign last   = !(q_word && q_addr[0]) || phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_word  <= 1'b0;
         q_write <= 1'b0;
         q_wdata <= '0;
      end else if (accept) begin
         q_addr  <= req_addr;
         q_word  <= req_word;
         q_write <= req_write;
         q_wdata <= req_wdata;
      end
   end

   bif_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .ready  (bus_ready),
      .last   (last),
      .state  (state),
      .phase  (phase),
      .done   (req_done),
      .strobe (strobe),
      .sample (sample)
   );

   bif_plan #(.AW(AW)) u_plan (
      .word  (q_word),
      .base  (q_addr),
      .phase (phase),
      .addr  (plan_addr),
      .be    (plan_be),
      .src   (plan_src)
   );

   always_comb begin
      rdata_nxt = rdata_q;
      if (accept) begin
         rdata_nxt = '0;
      end else if (sample && !q_write) begin
         for (int l = 0; l < BIF_LANES; l++) begin
            if (plan_be[l])
               rdata_nxt[int'(plan_src[l])*LW +: LW] = bus_din[l*LW +: LW];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rdata_nxt;
   end

   for (genvar l = 0; l < BIF_LANES; l++) begin : g_lane
      assign bus_dout[l*LW +: LW] = (bus_doe && plan_be[l]) ?
                                    q_wdata[int'(plan_src[l])*LW +: LW] : '0;
   end

   assign req_busy  = busy;
   assign req_rdata = rdata_q;
   assign bus_addr  = busy ? plan_addr : '0;
   assign bus_be    = busy ? plan_be : '0;
   assign bus_rd    = strobe && !q_write;
   assign bus_wr    = strobe && q_write;
   assign bus_doe   = strobe && q_write;
endmodule

// File: rtl/bus_if_unit_chk.sv
module bus_if_unit_chk #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_busy,
   input logic          req_done,
   input logic [AW-1:0] bus_addr,
   input logic [1:0]    bus_be,
   input logic          bus_rd,
   input logic          bus_wr,
   input logic [DW-1:0] bus_dout,
   input logic          bus_ready
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> !req_busy);

   // R3
   strobe_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd) || $rose(bus_wr)) |=> (bus_rd || bus_wr));

   // R4
   wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && $past(bus_rd || bus_wr) && !bus_ready)
      |=> (bus_rd || bus_wr));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && $past(bus_rd || bus_wr))
      |-> ($stable(bus_addr) && $stable(bus_be)));

   // R5
   lane_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_be != 2'b00));

   // R8
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && $past(bus_wr)) |-> $stable(bus_dout));

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
endmodule

bind bus_if_unit bus_if_unit_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_busy  (req_busy),
   .req_done  (req_done),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_dout  (bus_dout),
   .bus_ready (bus_ready)
);

// File: tb/bus_if_unit_bench.sv
module bus_if_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        req_busy, req_done;
   logic [15:0] req_rdata, bus_addr, bus_dout, bus_din;
   logic [1:0]  bus_be;
   logic        bus_rd, bus_wr, bus_doe;
   logic        bus_ready = 1'b0;

   int total = 0;
   int fails = 0;
   int w_cur = 0;
   int scnt = 0;

   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];

   always #5 clk = ~clk;

   bus_if_unit u_bus_if_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_doe(bus_doe), .bus_dout(bus_dout), .bus_din(bus_din),
      .bus_ready(bus_ready)
   );

   // external memory model, word-organised
   assign bus_din = {mem[{bus_addr[5:1], 1'b1}], mem[{bus_addr[5:1], 1'b0}]};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 1);
         scnt <= 0;
      end else begin
         scnt <= (bus_rd || bus_wr) ? scnt + 1 : 0;
         if (bus_wr && bus_ready && scnt >= 1) begin
            if (bus_be[0]) mem[{bus_addr[5:1], 1'b0}] <= bus_dout[7:0];
            if (bus_be[1]) mem[{bus_addr[5:1], 1'b1}] <= bus_dout[15:8];
         end
      end
   end

   // Ready goes high once the chosen number of wait states has elapsed
   always @(negedge clk) bus_ready <= (scnt >= 1 + w_cur);

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic access(input bit wr, input bit wd, input logic [15:0] a,
                         input logic [15:0] d, input int w);
      int n, first, nph, bad8, badbusy;
      logic prev;
      logic [15:0] ph_addr [2];
      logic [1:0]  ph_be [2];
      int exp_ph;
      logic [1:0] exp_be0;
      logic [15:0] exp_rd;
      n = 0; first = -1; nph = 0; bad8 = 0; badbusy = 0; prev = 1'b0;
      ph_addr[0] = '0; ph_addr[1] = '0; ph_be[0] = '0; ph_be[1] = '0;
      w_cur = w;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
      n = 1;
      // R9: previous pulse is gone one edge after this acceptance
      chk(!req_done, "R9 pulse single", int'(req_done), 0);
      while (!req_done && n < 80) begin
         if (!req_busy) badbusy++;
         if ((bus_rd || bus_wr) && !prev) begin
            if (first < 0) first = n;
            if (nph < 2) begin ph_addr[nph] = bus_addr; ph_be[nph] = bus_be; end
            nph++;
         end
         if (bus_wr && (!bus_doe || (!bus_be[0] && bus_dout[7:0] != 0) ||
                        (!bus_be[1] && bus_dout[15:8] != 0))) bad8++;
         prev = bus_rd || bus_wr;
         @(posedge clk); #1;
         n++;
      end
      exp_ph  = (wd && a[0]) ? 2 : 1;
      exp_be0 = !a[0] ? (wd ? 2'b11 : 2'b01) : 2'b10;
      // R2 / R4: completion cycle count
      chk(n == 1 + exp_ph * (4 + w), "R2 R4 cycle count", n, 1 + exp_ph * (4 + w));
      chk(first == 2, "R3 strobe in T2", first, 2);
      chk(badbusy == 0, "R10 busy span", badbusy, 0);
      chk(nph == exp_ph, "R6 cycle number", nph, exp_ph);
      chk(ph_be[0] == exp_be0 && ph_addr[0] == a, "R5 first cycle lanes",
          int'({ph_addr[0], 2'b00, ph_be[0]}), int'({a, 2'b00, exp_be0}));
      if (exp_ph == 2)
         chk(ph_be[1] == 2'b01 && ph_addr[1] == a + 16'd1, "R6 second cycle",
             int'({ph_addr[1], 2'b00, ph_be[1]}), int'({a + 16'd1, 4'b0001}));
      if (wr) begin
         exp_mem[a[5:0]] = d[7:0];
         if (wd) exp_mem[a[5:0] + 6'd1] = d[15:8];
         chk(bad8 == 0, "R8 write drive", bad8, 0);
      end else begin
         exp_rd = wd ? {exp_mem[a[5:0] + 6'd1], exp_mem[a[5:0]]} : {8'h00, exp_mem[a[5:0]]};
         chk(req_rdata == exp_rd, "R7 read data", int'(req_rdata), int'(exp_rd));
      end
   endtask

   task automatic mem_compare(input string req);
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] != exp_mem[i]) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      #2_000_000;
      fails++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 7 + 1);
      repeat (3) @(posedge clk);
      #1;
      // R1
      chk(!req_busy && !req_done && !bus_rd && !bus_wr && !bus_doe && bus_be == 2'b00,
          "R1 reset state", int'({req_busy, req_done, bus_rd, bus_wr, bus_doe, bus_be}), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(!req_busy && !bus_rd && !bus_wr, "R1 idle after reset",
          int'({req_busy, bus_rd, bus_wr}), 0);
      for (int w = 0; w < 3; w++) begin
         for (int wd = 0; wd < 2; wd++) begin
            for (int a = 8; a < 14; a++) begin
               access(1'b1, wd[0], 16'(a + w * 16), {8'(8'hA0 + a + w * 16), 8'(8'h30 + a * 3 + wd)}, w);
               mem_compare("R8 memory contents");
               access(1'b0, wd[0], 16'(a + w * 16), 16'h0, w);
            end
         end
      end
      // reads of untouched odd words across a lane boundary, back to back
      access(1'b0, 1'b1, 16'd61, 16'h0, 1);
      access(1'b0, 1'b0, 16'd3, 16'h0, 0);
      @(posedge clk); #1;
      chk(!req_done && !req_busy, "R9 idle after pulse",
          int'({req_done, req_busy}), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule